// File: doc/BRIEF.md
# Byte-Wide Configuration Image Loader

This block is a hardware master that pushes a configuration image into a programmable target device over a byte-wide slave port. A single start strobe, together with a total byte count, launches a load. The block first pulses the target's program line. It then waits for the target to report that it is ready. Next it raises write, select and the configuration clock. After that it streams the image one byte per configuration-clock cycle, taking each byte from an upstream valid/ready source. When the image is complete it releases select, then write, and keeps clocking the target until the target reports completion.

Every wait stage has its own timeout, measured in system clock cycles. The timeout counter is reloaded when the stage is entered. On expiry the block pulses an abort output for one cycle, returns every target line to its inactive level, goes back to idle, and holds an error code that names the stage which failed. All half-periods of the configuration clock, and the width of the program pulse, come from a programmable divider of the system clock. A half-period lasts `halfDiv+1` system cycles.

Top module: `pcfg_loader`

## Requirements
- R1: After reset, and whenever idle, progOut, selOut, wrOut, cclkOut, dataOut, inReady, loadDone and abortPulse are all 0, and errCode is 0 after reset.
- R2: A start sampled while idle raises progOut on the next cycle. progOut stays high for exactly halfDiv+1 cycles and then falls.
- R3: After the program pulse, the block advances only at a divider tick on which initIn and busyIn are not both high. If it has not advanced TIMEOUT_CYCLES cycles after entering this stage, it aborts with errCode 1.
- R4: wrOut, selOut and cclkOut rise together in one cycle, before any byte is taken.
- R5: inReady is high only while the block waits for the next byte. A taken byte appears on dataOut, cclkOut falls one half-period later, and rises one half-period after that. The byte is stable while the clock is low.
- R6: When busy checking is enabled and busyIn is high at the divider tick that follows a byte, the block pulses cclkOut (low for one half-period, then high) and takes no new byte until busyIn is low at a tick. If this stall lasts TIMEOUT_CYCLES cycles from the end of the byte, it aborts with errCode 2.
- R7: After the last byte, selOut falls one half-period before wrOut falls.
- R8: After wrOut falls, the block pulses cclkOut each half-period pair until it sees doneIn high at a tick. If doneIn does not arrive within TIMEOUT_CYCLES cycles, it aborts with errCode 3.
- R9: On any timeout, abortPulse is high for exactly one cycle, all target lines are driven to 0 in that same cycle, and errCode keeps its code until the next accepted start, which clears it to 0.
- R10: A successful load ends with a one-cycle loadDone pulse, all target lines at 0, and errCode 0.
- R11: A start strobe seen while a load is in progress has no effect on that load.
- R12: A byte count of 0 skips the data phase: inReady never rises, and the block goes straight from selection to the tail and done wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load (sampled while idle) |
| byteCount | input | LEN_W | Number of image bytes, captured at start |
| halfDiv | input | DIV_W | Half-period length minus one, in system cycles |
| inData | input | 8 | Upstream image byte |
| inValid | input | 1 | Upstream byte is valid |
| inReady | output | 1 | Loader accepts a byte this cycle |
| initIn | input | 1 | Target init indication (high = still initialising) |
| busyIn | input | 1 | Target busy indication |
| doneIn | input | 1 | Target configuration-complete indication |
| progOut | output | 1 | Program request to the target (high = asserted) |
| selOut | output | 1 | Chip select to the target (high = asserted) |
| wrOut | output | 1 | Write enable to the target (high = asserted) |
| cclkOut | output | 1 | Configuration clock to the target |
| dataOut | output | 8 | Data byte to the target |
| loadDone | output | 1 | One-cycle pulse on a successful load |
| abortPulse | output | 1 | One-cycle pulse on any timeout |
| errCode | output | 2 | 0 none, 1 init timeout, 2 busy timeout, 3 done timeout |

## Verification
The properties assume that the upstream source holds inData stable while inValid is high, that halfDiv stays constant during a load, and that halfDiv+1 is smaller than TIMEOUT_CYCLES. The bench changes halfDiv only at a start, and drives the target inputs from a small responder that reacts to the loader's own lines. That responder holds init and busy after the program pulse, raises busy for a set number of cycles after each byte, and raises done a set number of cycles after write drops. The scenarios choose these delays either below the timeout, so the load succeeds, or far above it, so a chosen stage times out. Upstream bytes come from a queue presented through the valid/ready handshake.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PROG,
    ST_INITW,
    ST_PUT,
    ST_FALL,
    ST_RISE,
    ST_POST,
    ST_BRISE,
    ST_DESEL,
    ST_WROFF,
    ST_DWAIT,
    ST_DRISE
  } stage_t;

  typedef logic [1:0] err_t;
  localparam err_t ERR_NONE = 2'd0;
  localparam err_t ERR_INIT = 2'd1;
  localparam err_t ERR_BUSY = 2'd2;
  localparam err_t ERR_DONE = 2'd3;

  typedef struct packed {
    logic divLoad;
    logic toLoad;
    logic remLoad;
    logic takeByte;
    logic progSet;
    logic progClr;
    logic selSet;
    logic selClr;
    logic wrSet;
    logic wrClr;
    logic clkHi;
    logic clkLo;
    logic allOff;
    logic doneP;
    logic abortP;
    logic errClr;
    logic errSet;
    err_t errVal;
  } ctl_t;

  typedef struct packed {
    logic tick;
    logic toZero;
    logic remZero;
  } stat_t;

endpackage

// File: rtl/pcfg_downcnt.sv
module pcfg_downcnt #(
  parameter int W    = 8,
  parameter bit WRAP = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  output logic         zero
);

  logic [W-1:0] cnt;
  logic         reload;

  generate
    if (WRAP) begin : g_wrap
      assign reload = load || (cnt == '0);
    end else begin : g_hold
      assign reload = load;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (reload) begin
      cnt <= loadVal;
    end else if (cnt != '0) begin
      cnt <= cnt - W'(1);
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/pcfg_datapath.sv
module pcfg_datapath
  import pcfg_pkg::*;
#(
  parameter int LEN_W          = 16,
  parameter int DIV_W          = 8,
  parameter int TIMEOUT_CYCLES = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctl_t             ctl,
  input  logic [LEN_W-1:0] byteCount,
  input  logic [DIV_W-1:0] halfDiv,
  input  logic [7:0]       inData,
  output stat_t            stat,
  output logic             progOut,
  output logic             selOut,
  output logic             wrOut,
  output logic             cclkOut,
  output logic [7:0]       dataOut,
  output logic             loadDone,
  output logic             abortPulse,
  output err_t             errCode
);

  localparam int TO_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TO_W-1:0] TO_RELOAD = TO_W'(TIMEOUT_CYCLES - 1);

  logic [LEN_W-1:0] remCnt;
  logic             tickW;
  logic             toZeroW;

  pcfg_downcnt #(.W(DIV_W), .WRAP(1'b1)) i_div (
    .clk(clk), .rstN(rstN), .load(ctl.divLoad), .loadVal(halfDiv), .zero(tickW)
  );

  pcfg_downcnt #(.W(TO_W), .WRAP(1'b0)) i_tmo (
    .clk(clk), .rstN(rstN), .load(ctl.toLoad), .loadVal(TO_RELOAD), .zero(toZeroW)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remCnt     <= '0;
      progOut    <= 1'b0;
      selOut     <= 1'b0;
      wrOut      <= 1'b0;
      cclkOut    <= 1'b0;
      dataOut    <= '0;
      loadDone   <= 1'b0;
      abortPulse <= 1'b0;
      errCode    <= ERR_NONE;
    end else begin
      if (ctl.remLoad)       remCnt <= byteCount;
      else if (ctl.takeByte) remCnt <= remCnt - LEN_W'(1);

      if (ctl.allOff)       progOut <= 1'b0;
      else if (ctl.progSet) progOut <= 1'b1;
      else if (ctl.progClr) progOut <= 1'b0;

      if (ctl.allOff)      selOut <= 1'b0;
      else if (ctl.selSet) selOut <= 1'b1;
      else if (ctl.selClr) selOut <= 1'b0;

      if (ctl.allOff)     wrOut <= 1'b0;
      else if (ctl.wrSet) wrOut <= 1'b1;
      else if (ctl.wrClr) wrOut <= 1'b0;

      if (ctl.allOff)     cclkOut <= 1'b0;
      else if (ctl.clkHi) cclkOut <= 1'b1;
      else if (ctl.clkLo) cclkOut <= 1'b0;

      if (ctl.allOff)        dataOut <= '0;
      else if (ctl.takeByte) dataOut <= inData;

      loadDone   <= ctl.doneP;
      abortPulse <= ctl.abortP;

      if (ctl.errClr)      errCode <= ERR_NONE;
      else if (ctl.errSet) errCode <= ctl.errVal;
    end
  end

  assign stat.tick    = tickW;
  assign stat.toZero  = toZeroW;
  assign stat.remZero = (remCnt == '0);

endmodule

// File: rtl/pcfg_ctrl.sv
module pcfg_ctrl
  import pcfg_pkg::*;
#(
  parameter bit CHECK_BUSY = 1'b1
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  input  logic  inValid,
  input  logic  initIn,
  input  logic  busyIn,
  input  logic  doneIn,
  input  stat_t stat,
  output ctl_t  ctl,
  output logic  inReady
);

  stage_t state, nxt;
  logic   abortReq;
  err_t   abortCode;
  logic   busyChk;

  assign busyChk = CHECK_BUSY && busyIn;
  assign inReady = (state == ST_PUT);

  always_comb begin
    ctl       = '0;
    nxt       = state;
    abortReq  = 1'b0;
    abortCode = ERR_NONE;
    unique case (state)
      ST_IDLE: begin
        ctl.divLoad = 1'b1;
        if (start) begin
          ctl.remLoad = 1'b1;
          ctl.errClr  = 1'b1;
          ctl.progSet = 1'b1;
          nxt         = ST_PROG;
        end
      end
      ST_PROG: if (stat.tick) begin
        ctl.progClr = 1'b1;
        ctl.toLoad  = 1'b1;
        nxt         = ST_INITW;
      end
      ST_INITW: begin
        if (stat.tick && !(initIn && busyIn)) begin
          ctl.wrSet  = 1'b1;
          ctl.selSet = 1'b1;
          ctl.clkHi  = 1'b1;
          nxt        = stat.remZero ? ST_DESEL : ST_PUT;
        end else if (stat.toZero) begin
          abortReq  = 1'b1;
          abortCode = ERR_INIT;
        end
      end
      ST_PUT: if (inValid) begin
        ctl.takeByte = 1'b1;
        nxt          = ST_FALL;
      end
      ST_FALL: if (stat.tick) begin
        ctl.clkLo = 1'b1;
        nxt       = ST_RISE;
      end
      ST_RISE: if (stat.tick) begin
        ctl.clkHi  = 1'b1;
        ctl.toLoad = 1'b1;
        nxt        = ST_POST;
      end
      ST_POST: begin
        if (stat.tick && !busyChk) begin
          nxt = stat.remZero ? ST_DESEL : ST_PUT;
        end else if (stat.toZero) begin
          abortReq  = 1'b1;
          abortCode = ERR_BUSY;
        end else if (stat.tick) begin
          ctl.clkLo = 1'b1;
          nxt       = ST_BRISE;
        end
      end
      ST_BRISE: begin
        if (stat.toZero) begin
          abortReq  = 1'b1;
          abortCode = ERR_BUSY;
        end else if (stat.tick) begin
          ctl.clkHi = 1'b1;
          nxt       = ST_POST;
        end
      end
      ST_DESEL: if (stat.tick) begin
        ctl.selClr = 1'b1;
        nxt        = ST_WROFF;
      end
      ST_WROFF: if (stat.tick) begin
        ctl.wrClr  = 1'b1;
        ctl.toLoad = 1'b1;
        nxt        = ST_DWAIT;
      end
      ST_DWAIT: begin
        if (stat.tick && doneIn) begin
          ctl.allOff = 1'b1;
          ctl.doneP  = 1'b1;
          nxt        = ST_IDLE;
        end else if (stat.toZero) begin
          abortReq  = 1'b1;
          abortCode = ERR_DONE;
        end else if (stat.tick) begin
          ctl.clkLo = 1'b1;
          nxt       = ST_DRISE;
        end
      end
      ST_DRISE: begin
        if (stat.toZero) begin
          abortReq  = 1'b1;
          abortCode = ERR_DONE;
        end else if (stat.tick) begin
          ctl.clkHi = 1'b1;
          nxt       = ST_DWAIT;
        end
      end
      default: nxt = ST_IDLE;
    endcase
    if (abortReq) begin
      ctl.allOff = 1'b1;
      ctl.abortP = 1'b1;
      ctl.errSet = 1'b1;
      ctl.errVal = abortCode;
      nxt        = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

endmodule

// File: rtl/pcfg_loader.sv
module pcfg_loader
  import pcfg_pkg::*;
#(
  parameter int LEN_W          = 16,
  parameter int DIV_W          = 8,
  parameter int TIMEOUT_CYCLES = 1000,
  parameter bit CHECK_BUSY     = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] byteCount,
  input  logic [DIV_W-1:0] halfDiv,
  input  logic [7:0]       inData,
  input  logic             inValid,
  output logic             inReady,
  input  logic             initIn,
  input  logic             busyIn,
  input  logic             doneIn,
  output logic             progOut,
  output logic             selOut,
  output logic             wrOut,
  output logic             cclkOut,
  output logic [7:0]       dataOut,
  output logic             loadDone,
  output logic             abortPulse,
  output logic [1:0]       errCode
);

  ctl_t  ctl;
  stat_t stat;

  pcfg_ctrl #(.CHECK_BUSY(CHECK_BUSY)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid),
    .initIn(initIn), .busyIn(busyIn), .doneIn(doneIn),
    .stat(stat), .ctl(ctl), .inReady(inReady)
  );

  pcfg_datapath #(
    .LEN_W(LEN_W), .DIV_W(DIV_W), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .byteCount(byteCount),
    .halfDiv(halfDiv), .inData(inData), .stat(stat),
    .progOut(progOut), .selOut(selOut), .wrOut(wrOut), .cclkOut(cclkOut),
    .dataOut(dataOut), .loadDone(loadDone), .abortPulse(abortPulse),
    .errCode(errCode)
  );

endmodule

// File: rtl/pcfg_checker.sv
module pcfg_checker (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       inReady,
  input logic       progOut,
  input logic       selOut,
  input logic       wrOut,
  input logic       cclkOut,
  input logic [7:0] dataOut,
  input logic       loadDone,
  input logic       abortPulse,
  input logic [1:0] errCode
);

  // R2: program request never overlaps selection or write
  p_prog_alone_r2: assert property (@(posedge clk) disable iff (!rstN)
    progOut |-> (!selOut && !wrOut));

  // R5: a byte is only requested with the target selected and clock high
  p_ready_selected_r5: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (selOut && wrOut && cclkOut && !progOut));

  // R5: data stays put across a normal clock fall
  p_data_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(cclkOut) && !abortPulse && !loadDone) |-> $stable(dataOut));

  // R7: select is never active without write
  p_sel_within_wr_r7: assert property (@(posedge clk) disable iff (!rstN)
    selOut |-> wrOut);

  // R9: abort is a single-cycle pulse
  p_abort_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |=> !abortPulse);

  // R9: all target lines inactive while abort pulses
  p_abort_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> (!progOut && !selOut && !wrOut && !cclkOut && dataOut == 8'h00));

  // R9: error code changes only on an abort or after a start
  p_err_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(errCode) |-> (abortPulse || $past(start)));

  // R10: done is a single-cycle pulse exclusive with abort
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> !loadDone);

  p_done_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(loadDone && abortPulse));

endmodule

bind pcfg_loader pcfg_checker i_chk (
  .clk(clk), .rstN(rstN), .start(start), .inReady(inReady),
  .progOut(progOut), .selOut(selOut), .wrOut(wrOut), .cclkOut(cclkOut),
  .dataOut(dataOut), .loadDone(loadDone), .abortPulse(abortPulse),
  .errCode(errCode)
);

// File: tb/test_pcfg_loader.sv
`timescale 1ns/1ps
module test_pcfg_loader;

  localparam int TMO = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] byteCount = '0;
  logic [7:0]  halfDiv = '0;
  logic [7:0]  inData = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic        initIn = 1'b0;
  logic        busyIn = 1'b0;
  logic        doneIn = 1'b0;
  logic        progOut, selOut, wrOut, cclkOut, loadDone, abortPulse;
  logic [7:0]  dataOut;
  logic [1:0]  errCode;

  always #5 clk = ~clk;

  pcfg_loader #(.LEN_W(16), .DIV_W(8), .TIMEOUT_CYCLES(TMO), .CHECK_BUSY(1'b1)) i_pcfg_loader (
    .clk(clk), .rstN(rstN), .start(start), .byteCount(byteCount), .halfDiv(halfDiv),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .initIn(initIn), .busyIn(busyIn), .doneIn(doneIn),
    .progOut(progOut), .selOut(selOut), .wrOut(wrOut), .cclkOut(cclkOut),
    .dataOut(dataOut), .loadDone(loadDone), .abortPulse(abortPulse), .errCode(errCode)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  localparam int S_IDLE = 0, S_PROG = 1, S_INIT = 2, S_PUT = 3, S_FALL = 4, S_RISE = 5,
                 S_POST = 6, S_BRISE = 7, S_DESEL = 8, S_WROFF = 9, S_DWAIT = 10, S_DRISE = 11;
  int rStage, rDiv, rTo, rRem;
  bit eProg, eSel, eWr, eClk, eDone, eAbort;
  logic [7:0] eData;
  logic [1:0] eErr;

  task automatic quietAll();
    eProg = 0; eSel = 0; eWr = 0; eClk = 0; eData = 8'h00;
  endtask

  task automatic failWith(input int code);
    quietAll(); eAbort = 1; eErr = 2'(code);
  endtask

  always @(posedge clk) begin : ref_model
    int ns, nDiv, nTo;
    bit tk, tz;
    if (!rstN) begin
      rStage = S_IDLE; rDiv = 0; rTo = 0; rRem = 0;
      quietAll(); eDone = 0; eAbort = 0; eErr = 0;
    end else begin
      tk = (rDiv == 0);
      tz = (rTo == 0);
      nDiv = (rStage == S_IDLE || tk) ? int'(halfDiv) : rDiv - 1;
      nTo = (rTo > 0) ? rTo - 1 : 0;
      eDone = 0; eAbort = 0; ns = rStage;
      case (rStage)
        S_IDLE: if (start) begin rRem = int'(byteCount); eErr = 0; eProg = 1; ns = S_PROG; end
        S_PROG: if (tk) begin eProg = 0; nTo = TMO - 1; ns = S_INIT; end
        S_INIT: if (tk && !(initIn && busyIn)) begin
                  eWr = 1; eSel = 1; eClk = 1; ns = (rRem == 0) ? S_DESEL : S_PUT;
                end else if (tz) begin failWith(1); ns = S_IDLE; end
        S_PUT: if (inValid) begin eData = inData; rRem--; ns = S_FALL; end
        S_FALL: if (tk) begin eClk = 0; ns = S_RISE; end
        S_RISE: if (tk) begin eClk = 1; nTo = TMO - 1; ns = S_POST; end
        S_POST: if (tk && !busyIn) ns = (rRem == 0) ? S_DESEL : S_PUT;
                else if (tz) begin failWith(2); ns = S_IDLE; end
                else if (tk) begin eClk = 0; ns = S_BRISE; end
        S_BRISE: if (tz) begin failWith(2); ns = S_IDLE; end
                 else if (tk) begin eClk = 1; ns = S_POST; end
        S_DESEL: if (tk) begin eSel = 0; ns = S_WROFF; end
        S_WROFF: if (tk) begin eWr = 0; nTo = TMO - 1; ns = S_DWAIT; end
        S_DWAIT: if (tk && doneIn) begin quietAll(); eDone = 1; ns = S_IDLE; end
                 else if (tz) begin failWith(3); ns = S_IDLE; end
                 else if (tk) begin eClk = 0; ns = S_DRISE; end
        S_DRISE: if (tz) begin failWith(3); ns = S_IDLE; end
                 else if (tk) begin eClk = 1; ns = S_DWAIT; end
        default: ns = S_IDLE;
      endcase
      rStage = ns; rDiv = nDiv; rTo = nTo;
    end
  end

  function automatic string tagOf(input int st, input bit ab);
    if (ab) return "R9";
    case (st)
      S_IDLE: return "R1";
      S_PROG: return "R2";
      S_INIT: return "R3";
      S_POST, S_BRISE: return "R6";
      S_DESEL, S_WROFF: return "R7";
      S_DWAIT, S_DRISE: return "R8";
      default: return "R5";
    endcase
  endfunction

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    logic [15:0] act, exp;
    if (rstN && !finished) begin
      act = {inReady, progOut, selOut, wrOut, cclkOut, loadDone, abortPulse, 1'b0, dataOut};
      exp = {(rStage == S_PUT), eProg, eSel, eWr, eClk, eDone, eAbort, 1'b0, eData};
      compared++;
      if (act != exp || errCode != eErr) begin
        mismatched++;
        $display("FAIL %s cycle compare: actual %h/%0d expected %h/%0d",
                 tagOf(rStage, eAbort), act, errCode, exp, eErr);
      end
    end
  end

  // ---------------- stimulus: upstream source and target responder ----------------
  logic [7:0] upQ[$];
  int initDelay = 0, busyLen = 0, doneDelay = 0;
  bit lastOffer = 0;
  int initCnt = 0, busyCnt = 0, doneCnt = 0;
  bit initHigh = 0, doneArm = 0, wrPrev = 0;

  always @(negedge clk) begin
    if (lastOffer) begin
      void'(upQ.pop_front());
      busyCnt = busyLen;
    end
    inValid = (upQ.size() > 0);
    inData  = (upQ.size() > 0) ? upQ[0] : 8'h00;
    lastOffer = inReady && inValid;

    if (progOut) begin
      initCnt = initDelay; initHigh = 1; doneArm = 0; busyCnt = 0;
    end else if (initHigh) begin
      if (initCnt > 0) initCnt--; else initHigh = 0;
    end
    initIn = initHigh;
    busyIn = initHigh || (busyCnt > 0);
    if (busyCnt > 0) busyCnt--;

    if (wrPrev && !wrOut && !progOut) begin
      doneArm = 1; doneCnt = doneDelay;
    end else if (doneArm && doneCnt > 0) begin
      doneCnt--;
    end
    doneIn = doneArm && (doneCnt == 0);
    wrPrev = wrOut;
  end

  // ---------------- observation of the target lines ----------------
  logic [7:0] capQ[$];
  int cyc = 0, progHigh = 0, progWidth = 0, progRises = 0, tailClocks = 0, dataRises = 0;
  int selFallCyc = -1, wrFallCyc = -1;
  bit readySeen = 0, endSeen = 0, selRiseOk = 1, sawDone = 0, sawAbort = 0;
  logic prevProg = 0, prevSel = 0, prevWr = 0, prevClk = 0;

  task automatic clearObs();
    capQ.delete(); progHigh = 0; progWidth = 0; progRises = 0; tailClocks = 0; dataRises = 0;
    selFallCyc = -1; wrFallCyc = -1; readySeen = 0; endSeen = 0; selRiseOk = 1;
    sawDone = 0; sawAbort = 0;
  endtask

  always @(negedge clk) begin
    if (progOut) progHigh++;
    if (progOut && !prevProg) progRises++;
    if (prevProg && !progOut) progWidth = progHigh;
    if (selOut && !prevSel) selRiseOk = selRiseOk && wrOut && cclkOut && !prevWr && !prevClk && (capQ.size() == 0);
    if (prevSel && !selOut) selFallCyc = cyc;
    if (prevWr && !wrOut) wrFallCyc = cyc;
    if (cclkOut && !prevClk && prevSel && selOut) begin capQ.push_back(dataOut); dataRises++; end
    if (cclkOut && !prevClk && !selOut) tailClocks++;
    if (inReady) readySeen = 1;
    if (loadDone) begin endSeen = 1; sawDone = 1; end
    if (abortPulse) begin endSeen = 1; sawAbort = 1; end
    prevProg = progOut; prevSel = selOut; prevWr = wrOut; prevClk = cclkOut;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  logic [7:0] sent[$];

  task automatic runLoad(input int n, input int hd, input int iD, input int bL, input int dD,
                         input bit midStart);
    int k;
    sent.delete();
    for (int i = 0; i < n; i++) begin
      sent.push_back(8'(8'h3C + i * 29 + hd * 7));
      upQ.push_back(8'(8'h3C + i * 29 + hd * 7));
    end
    initDelay = iD; busyLen = bL; doneDelay = dD;
    clearObs();
    @(negedge clk);
    byteCount = 16'(n); halfDiv = 8'(hd); start = 1;
    @(negedge clk);
    start = 0;
    k = 0;
    while (!endSeen && k < 20000) begin
      @(negedge clk);
      k++;
      if (midStart && (k == 15 || k == 40)) start = 1; else start = 0;
    end
    start = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(progOut == 0 && selOut == 0 && wrOut == 0 && cclkOut == 0 && inReady == 0 && errCode == 0,
        "R1 reset state quiet", {progOut, selOut, wrOut, cclkOut, inReady}, 0);
    rstN = 1;
    repeat (3) @(negedge clk);
    chk(dataOut == 8'h00 && loadDone == 0 && abortPulse == 0, "R1 idle after reset", dataOut, 0);

    // A: fastest divider, no busy
    runLoad(3, 0, 3, 0, 4, 0);
    chk(sawDone && !sawAbort && errCode == 0, "R10 success A", errCode, 0);
    chk(progWidth == 1, "R2 program width A", progWidth, 1);
    chk(selRiseOk, "R4 lines rise together A", selRiseOk, 1);
    chk(capQ.size() == 3 && capQ == sent, "R5 bytes on bus A", capQ.size(), 3);
    chk(wrFallCyc - selFallCyc == 1, "R7 select before write A", wrFallCyc - selFallCyc, 1);
    chk(tailClocks > 0, "R8 done clocks A", tailClocks, 1);

    // B: busy stalls
    runLoad(2, 2, 5, 12, 5, 0);
    chk(sawDone && errCode == 0, "R6 stall then success", errCode, 0);
    chk(dataRises > 2, "R6 extra clocks during busy", dataRises, 3);
    chk(progWidth == 3, "R2 program width B", progWidth, 3);

    // C: zero bytes
    runLoad(0, 1, 2, 0, 3, 0);
    chk(sawDone && !readySeen, "R12 no data phase", readySeen, 0);
    chk(capQ.size() == 0, "R12 no bytes clocked", capQ.size(), 0);

    // D: init timeout
    runLoad(1, 1, 1000, 0, 3, 0);
    upQ.delete();
    chk(sawAbort && errCode == 1, "R3 init timeout code", errCode, 1);
    repeat (5) @(negedge clk);
    chk(errCode == 1 && !progOut && !selOut && !wrOut, "R9 code held, lines quiet", errCode, 1);

    // E: busy timeout
    runLoad(2, 1, 2, 1000, 3, 0);
    upQ.delete();
    chk(sawAbort && errCode == 2, "R6 busy timeout code", errCode, 2);

    // F: done timeout
    runLoad(1, 1, 2, 0, 100000, 0);
    chk(sawAbort && errCode == 3, "R8 done timeout code", errCode, 3);

    // G: start during load is ignored, longer divider
    runLoad(6, 3, 2, 0, 3, 1);
    chk(sawDone && errCode == 0, "R11 load completes", errCode, 0);
    chk(progRises == 1, "R11 single program pulse", progRises, 1);
    chk(capQ == sent, "R11 bytes unchanged", capQ.size(), 6);
    chk(wrFallCyc - selFallCyc == 4, "R7 select before write G", wrFallCyc - selFallCyc, 4);
    chk(sawDone, "R9 code cleared by next start", errCode, 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule